// File: doc/BRIEF.md
# Quad DAC Command Register Bank

This block sits between the serial front end of a four-channel DAC controller and the analog channels. The serial block assembles a 32-bit frame and pulses `cmd_valid` for one clock when the frame is complete. This block then decodes the frame and acts on it. Each channel has two codes. A buffer code receives new data, and an output latch holds the code that drives the converter. Each channel also has a power-down mode. The block holds several global settings: the clear-code selection, a per-channel mask that makes buffer writes go straight to the latch, a per-channel current-limit mask, and the serial-output enable.

Channel codes leave reset at zero scale or mid scale, depending on the `por_mid` strap. A software reset command returns the block to the same state. A read frame performs no write. Instead it records which register was asked for, and from the next clock `rd_word` presents that register's contents in frame layout, ready for the serial block to shift out during the next transfer. The block assumes that `rst_n` is asserted asynchronously and has already been released in step with `clk` upstream.

Top module: `dac_cmd_regbank`

## Requirements
- R1: A frame is acted on only in a clock where `cmd_valid` is 1. Its fields are: bit 28 read flag (1 = read), bits 27:24 opcode, bits 23:20 channel, bits 19:4 16-bit code (D9:D8 = code bits 5:4), bits 3:0 mode nibble. Bits 31:29 are ignored.
- R2: Channel values 0,1,2,3 address channels A,B,C,D (channel i at `dac_code[16*i +: 16]`, and bit i of every mask). Value 15 addresses all four. Any other value makes opcodes 0–3 do nothing.
- R3: Opcode 0 loads the buffer of each addressed channel. The latch of an addressed channel also loads that code when the channel's bit is set in the direct-update mask.
- R4: Opcode 1 copies each addressed buffer into its latch. Opcode 3 loads buffer and latch with the code. Opcode 2 loads the addressed buffers and then copies every buffer into its latch.
- R5: Opcode 4 sets the power-down mode of every channel whose mode-nibble bit is 1 to D9:D8 (00 on, 01 1 k to ground, 10 100 k to ground, 11 open). A channel that is powered down still accepts buffer and latch writes, and its mode is left unchanged by them.
- R6: Opcode 5 loads the clear selection from mode bits 1:0. Opcode 6 loads the direct-update mask from the mode nibble. Opcode 10 loads the current-limit mask from the mode nibble. Opcode 8 loads the serial-output enable from mode bit 1.
- R7: Opcode 11 loads every buffer and every latch with the clear code: 0x0000 for selection 00, 0x8000 for 01, 0xFFFF for 10, and 0x0000 for 11.
- R8: During reset, every buffer and latch holds 0x8000 if `por_mid` is 1 and 0x0000 otherwise. All modes and masks are 0, and the read selection is opcode 14 with channel 0. Opcode 7 restores the same state, using the current `por_mid`.
- R9: `ready` is 0 during reset, becomes 1 at the first clock after release, and then stays 1, including through a software reset.
- R10: A read frame changes no register. It stores its opcode and channel, and from the next clock `rd_word` holds 0 in bits 31:28, the stored opcode in bits 27:24, the stored channel in bits 23:20, and the following payload:
  - opcode 0: the buffer of channel 0–3 in bits 19:4, or 0 for any other channel;
  - opcode 4: each channel's mode in bits 2i+5:2i+4;
  - opcodes 5, 6 and 10: the register in the same mode bits it was written from;
  - opcode 8: the enable in bit 1;
  - opcode 13: `ready` in bit 4.
  All other payload bits are 0.
- R11: Opcodes 9, 12, 15 (reserved) and 14 (no-op) change no register when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_mid | input | 1 | Reset-code strap: 1 selects mid scale |
| cmd_valid | input | 1 | One-cycle strobe for a completed frame |
| cmd_word | input | 32 | Completed frame |
| dac_code | output | 64 | Output latch codes, channel i in bits 16i+15:16i |
| pd_mode | output | 8 | Power-down mode, channel i in bits 2i+1:2i |
| clr_mode | output | 2 | Clear-code selection |
| ldac_ign | output | 4 | Direct-update mask |
| sc_lim | output | 4 | Current-limit mask |
| sdo_en | output | 1 | Serial-output enable |
| ready | output | 1 | Ready flag |
| rd_word | output | 32 | Readback frame for the next transfer |

## Verification
The bench targets these corner cases, and each one describes what a faulty design would do:
- **Broadcast followed by opcode 2.** A design that copied only the addressed buffer would leave the other latches stale.
- **Unmapped channel codes.** A design that decoded only the low two bits would write the wrong channel.
- **Direct-update mask.** The bench toggles the mask and then writes buffers. A design that ignored the mask would leave latches unchanged, or would move latches that are not masked.
- **Read frame carrying a write opcode.** A design that decoded opcodes without checking the read flag would corrupt a latch.
- **Clear selection 11.** This must give zero and not full scale.
- **Software reset under both strap values.** A design that hard-wired zero scale, or cleared `ready`, would diverge from the reference model on the next compare.

// File: rtl/dac_rb_pkg.sv
package dac_rb_pkg;
  localparam int CODE_W  = 16;
  localparam int FRAME_W = 32;
  localparam int CHAN_W  = 4;
  localparam logic [CODE_W-1:0] MID_CODE  = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] FULL_CODE = '1;

  typedef enum logic [3:0] {
    OP_WR_BUF     = 4'h0,
    OP_UPD        = 4'h1,
    OP_WR_UPD_ALL = 4'h2,
    OP_WR_UPD     = 4'h3,
    OP_PWR        = 4'h4,
    OP_CLRSEL     = 4'h5,
    OP_DIRMASK    = 4'h6,
    OP_SWRST      = 4'h7,
    OP_SDO        = 4'h8,
    OP_RSV9       = 4'h9,
    OP_ILIM       = 4'hA,
    OP_SWCLR      = 4'hB,
    OP_RSVC       = 4'hC,
    OP_STATUS     = 4'hD,
    OP_NOP        = 4'hE,
    OP_RSVF       = 4'hF
  } op_e;

  typedef struct packed {
    logic [2:0]        pad;
    logic              rd;
    op_e               op;
    logic [CHAN_W-1:0] chan;
    logic [CODE_W-1:0] data;
    logic [3:0]        mode;
  } frame_t;

  function automatic logic [CODE_W-1:0] clear_code(input logic [1:0] sel);
    case (sel)
      2'b01:   return MID_CODE;
      2'b10:   return FULL_CODE;
      default: return '0;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] por_code(input logic mid);
    return mid ? MID_CODE : '0;
  endfunction
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_rb_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                valid,
  input  logic                rd,
  input  op_e                 op,
  input  logic [CHAN_W-1:0]   chan,
  input  logic [1:0]          pd_bits,
  input  logic [3:0]          mode,
  input  logic [NUM_CH-1:0]   ldac_ign,
  input  logic [1:0]          clr_sel,
  input  logic                por_mid,
  output logic [NUM_CH-1:0]   buf_ld,
  output logic [NUM_CH-1:0]   lat_ld,
  output logic [NUM_CH-1:0]   pd_ld,
  output logic [1:0]          pd_d,
  output logic                fill_ld,
  output logic [CODE_W-1:0]   fill_code,
  output logic                clrm_ld,
  output logic                dir_ld,
  output logic                ilim_ld,
  output logic                sdo_ld,
  output logic                sw_rst,
  output logic                rd_ld
);
  logic [NUM_CH-1:0] sel;
  logic              any_sel;
  logic              wr;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign sel[i] = (chan == CHAN_W'(i)) || (chan == '1);
  end

  assign any_sel = |sel;
  assign wr      = valid & ~rd;

  always_comb begin
    buf_ld    = '0;
    lat_ld    = '0;
    pd_ld     = '0;
    pd_d      = pd_bits;
    fill_ld   = 1'b0;
    fill_code = clear_code(clr_sel);
    clrm_ld   = 1'b0;
    dir_ld    = 1'b0;
    ilim_ld   = 1'b0;
    sdo_ld    = 1'b0;
    sw_rst    = 1'b0;
    rd_ld     = valid & rd;
    if (wr) begin
      case (op)
        OP_WR_BUF: begin
          buf_ld = sel;
          lat_ld = sel & ldac_ign;
        end
        OP_UPD:        lat_ld = sel;
        OP_WR_UPD_ALL: begin
          buf_ld = sel;
          lat_ld = any_sel ? '1 : '0;
        end
        OP_WR_UPD: begin
          buf_ld = sel;
          lat_ld = sel;
        end
        OP_PWR:     pd_ld   = mode[NUM_CH-1:0];
        OP_CLRSEL:  clrm_ld = 1'b1;
        OP_DIRMASK: dir_ld  = 1'b1;
        OP_ILIM:    ilim_ld = 1'b1;
        OP_SDO:     sdo_ld  = 1'b1;
        OP_SWRST: begin
          sw_rst    = 1'b1;
          fill_ld   = 1'b1;
          fill_code = por_code(por_mid);
          pd_ld     = '1;
          pd_d      = 2'b00;
        end
        OP_SWCLR: fill_ld = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs
  import dac_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] rst_code,
  input  logic              buf_ld,
  input  logic [CODE_W-1:0] buf_d,
  input  logic              lat_ld,
  input  logic              fill_ld,
  input  logic [CODE_W-1:0] fill_code,
  input  logic              pd_ld,
  input  logic [1:0]        pd_d,
  output logic [CODE_W-1:0] buf_q,
  output logic [CODE_W-1:0] lat_q,
  output logic [1:0]        pd_q
);
  logic [CODE_W-1:0] buf_n, lat_n;
  logic [1:0]        pd_n;

  always_comb begin
    buf_n = buf_q;
    lat_n = lat_q;
    pd_n  = pd_q;
    if (fill_ld) begin
      buf_n = fill_code;
      lat_n = fill_code;
    end else begin
      if (buf_ld) buf_n = buf_d;
      if (lat_ld) lat_n = buf_n;
    end
    if (pd_ld) pd_n = pd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= rst_code;
      lat_q <= rst_code;
      pd_q  <= 2'b00;
    end else begin
      buf_q <= buf_n;
      lat_q <= lat_n;
      pd_q  <= pd_n;
    end
  end

  // R4: the latch moves only on an update or a fill
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_ld && !fill_ld) |=> $stable(lat_q));

  // R5: power-down changes leave the codes alone
  p_pd_keeps_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_ld && !fill_ld && !buf_ld && !lat_ld) |=> ($stable(lat_q) && $stable(buf_q)));
endmodule

// File: rtl/dac_cfg_regs.sv
module dac_cfg_regs
  import dac_rb_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clrm_ld,
  input  logic              dir_ld,
  input  logic              ilim_ld,
  input  logic              sdo_ld,
  input  logic              sw_rst,
  input  logic              rd_ld,
  input  logic [3:0]        mode,
  input  op_e               op,
  input  logic [CHAN_W-1:0] chan,
  output logic [1:0]        clr_sel,
  output logic [NUM_CH-1:0] dir_mask,
  output logic [NUM_CH-1:0] ilim_mask,
  output logic              sdo_en,
  output logic              ready,
  output op_e               rd_op,
  output logic [CHAN_W-1:0] rd_chan
);
  logic [1:0]        clr_sel_n;
  logic [NUM_CH-1:0] dir_mask_n, ilim_mask_n;
  logic              sdo_en_n;
  op_e               rd_op_n;
  logic [CHAN_W-1:0] rd_chan_n;

  always_comb begin
    clr_sel_n   = clr_sel;
    dir_mask_n  = dir_mask;
    ilim_mask_n = ilim_mask;
    sdo_en_n    = sdo_en;
    rd_op_n     = rd_op;
    rd_chan_n   = rd_chan;
    if (sw_rst) begin
      clr_sel_n   = '0;
      dir_mask_n  = '0;
      ilim_mask_n = '0;
      sdo_en_n    = 1'b0;
      rd_op_n     = OP_NOP;
      rd_chan_n   = '0;
    end else begin
      if (clrm_ld) clr_sel_n   = mode[1:0];
      if (dir_ld)  dir_mask_n  = mode[NUM_CH-1:0];
      if (ilim_ld) ilim_mask_n = mode[NUM_CH-1:0];
      if (sdo_ld)  sdo_en_n    = mode[1];
      if (rd_ld) begin
        rd_op_n   = op;
        rd_chan_n = chan;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_sel   <= '0;
      dir_mask  <= '0;
      ilim_mask <= '0;
      sdo_en    <= 1'b0;
      ready     <= 1'b0;
      rd_op     <= OP_NOP;
      rd_chan   <= '0;
    end else begin
      clr_sel   <= clr_sel_n;
      dir_mask  <= dir_mask_n;
      ilim_mask <= ilim_mask_n;
      sdo_en    <= sdo_en_n;
      ready     <= 1'b1;
      rd_op     <= rd_op_n;
      rd_chan   <= rd_chan_n;
    end
  end

  // R9: once set, ready never drops outside reset
  p_ready_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R10: a recorded read target follows a read strobe
  p_rdsel_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ld |=> (rd_op == $past(op) && rd_chan == $past(chan)));
endmodule

// File: rtl/dac_readback.sv
module dac_readback
  import dac_rb_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  op_e                      rd_op,
  input  logic [CHAN_W-1:0]        rd_chan,
  input  logic [NUM_CH*CODE_W-1:0] buf_all,
  input  logic [2*NUM_CH-1:0]      pd_all,
  input  logic [1:0]               clr_sel,
  input  logic [NUM_CH-1:0]        dir_mask,
  input  logic [NUM_CH-1:0]        ilim_mask,
  input  logic                     sdo_en,
  input  logic                     ready,
  output logic [FRAME_W-1:0]       rd_word
);
  frame_t rw;

  always_comb begin
    rw      = '0;
    rw.op   = rd_op;
    rw.chan = rd_chan;
    case (rd_op)
      OP_WR_BUF: begin
        for (int i = 0; i < NUM_CH; i++)
          if (rd_chan == CHAN_W'(i)) rw.data = buf_all[i*CODE_W +: CODE_W];
      end
      OP_PWR:     rw.data[2*NUM_CH-1:0] = pd_all;
      OP_CLRSEL:  rw.mode[1:0]          = clr_sel;
      OP_DIRMASK: rw.mode[NUM_CH-1:0]   = dir_mask;
      OP_ILIM:    rw.mode[NUM_CH-1:0]   = ilim_mask;
      OP_SDO:     rw.mode[1]            = sdo_en;
      OP_STATUS:  rw.data[0]            = ready;
      default: ;
    endcase
    rd_word = rw;
  end
endmodule

// File: rtl/dac_cmd_regbank.sv
module dac_cmd_regbank
  import dac_rb_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     por_mid,
  input  logic                     cmd_valid,
  input  logic [FRAME_W-1:0]       cmd_word,
  output logic [NUM_CH*CODE_W-1:0] dac_code,
  output logic [2*NUM_CH-1:0]      pd_mode,
  output logic [1:0]               clr_mode,
  output logic [NUM_CH-1:0]        ldac_ign,
  output logic [NUM_CH-1:0]        sc_lim,
  output logic                     sdo_en,
  output logic                     ready,
  output logic [FRAME_W-1:0]       rd_word
);
  frame_t frm;
  logic   unused_pad;
  assign frm        = frame_t'(cmd_word);
  assign unused_pad = ^frm.pad;

  logic [NUM_CH-1:0]        buf_ld, lat_ld, pd_ld;
  logic [1:0]               pd_d;
  logic                     fill_ld;
  logic [CODE_W-1:0]        fill_code;
  logic                     clrm_ld, dir_ld, ilim_ld, sdo_ld, sw_rst, rd_ld;
  logic [NUM_CH*CODE_W-1:0] buf_all;
  op_e                      rd_op;
  logic [CHAN_W-1:0]        rd_chan;

  dac_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
    .valid(cmd_valid), .rd(frm.rd), .op(frm.op), .chan(frm.chan),
    .pd_bits(frm.data[5:4]), .mode(frm.mode), .ldac_ign(ldac_ign),
    .clr_sel(clr_mode), .por_mid(por_mid), .buf_ld(buf_ld), .lat_ld(lat_ld),
    .pd_ld(pd_ld), .pd_d(pd_d), .fill_ld(fill_ld), .fill_code(fill_code),
    .clrm_ld(clrm_ld), .dir_ld(dir_ld), .ilim_ld(ilim_ld), .sdo_ld(sdo_ld),
    .sw_rst(sw_rst), .rd_ld(rd_ld)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dac_chan_regs u_ch (
      .clk(clk), .rst_n(rst_n), .rst_code(por_code(por_mid)),
      .buf_ld(buf_ld[i]), .buf_d(frm.data), .lat_ld(lat_ld[i]),
      .fill_ld(fill_ld), .fill_code(fill_code), .pd_ld(pd_ld[i]), .pd_d(pd_d),
      .buf_q(buf_all[i*CODE_W +: CODE_W]), .lat_q(dac_code[i*CODE_W +: CODE_W]),
      .pd_q(pd_mode[2*i +: 2])
    );
  end

  dac_cfg_regs #(.NUM_CH(NUM_CH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .clrm_ld(clrm_ld), .dir_ld(dir_ld),
    .ilim_ld(ilim_ld), .sdo_ld(sdo_ld), .sw_rst(sw_rst), .rd_ld(rd_ld),
    .mode(frm.mode), .op(frm.op), .chan(frm.chan), .clr_sel(clr_mode),
    .dir_mask(ldac_ign), .ilim_mask(sc_lim), .sdo_en(sdo_en), .ready(ready),
    .rd_op(rd_op), .rd_chan(rd_chan)
  );

  dac_readback #(.NUM_CH(NUM_CH)) u_rb (
    .rd_op(rd_op), .rd_chan(rd_chan), .buf_all(buf_all), .pd_all(pd_mode),
    .clr_sel(clr_mode), .dir_mask(ldac_ign), .ilim_mask(sc_lim),
    .sdo_en(sdo_en), .ready(ready), .rd_word(rd_word)
  );

  // R11: reserved and no-op frames leave all state alone
  p_reserved_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !frm.rd && (frm.op inside {OP_RSV9, OP_RSVC, OP_RSVF, OP_NOP}))
    |=> ($stable(dac_code) && $stable(pd_mode) && $stable(clr_mode) &&
         $stable(ldac_ign) && $stable(sc_lim) && $stable(sdo_en)));

  // R10: a read frame writes nothing
  p_read_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && frm.rd)
    |=> ($stable(dac_code) && $stable(pd_mode) && $stable(clr_mode) &&
         $stable(ldac_ign) && $stable(sc_lim) && $stable(sdo_en)));

  // R6: clear selection load
  p_clrsel_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !frm.rd && frm.op == OP_CLRSEL) |=> (clr_mode == $past(cmd_word[1:0])));

  // R7: software clear drives the selected code
  p_swclr_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !frm.rd && frm.op == OP_SWCLR)
    |=> (dac_code[CODE_W-1:0] == clear_code($past(clr_mode))));

  // R1: no strobe, no change
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(dac_code) && $stable(pd_mode) && $stable(rd_word[27:20])));
endmodule

// File: tb/dac_cmd_regbank_test.sv
`timescale 1ns/1ps
module dac_cmd_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_mid = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [63:0] dac_code;
  logic [7:0]  pd_mode;
  logic [1:0]  clr_mode;
  logic [3:0]  ldac_ign, sc_lim;
  logic        sdo_en, ready;
  logic [31:0] rd_word;

  dac_cmd_regbank uut (
    .clk(clk), .rst_n(rst_n), .por_mid(por_mid), .cmd_valid(cmd_valid),
    .cmd_word(cmd_word), .dac_code(dac_code), .pd_mode(pd_mode),
    .clr_mode(clr_mode), .ldac_ign(ldac_ign), .sc_lim(sc_lim),
    .sdo_en(sdo_en), .ready(ready), .rd_word(rd_word)
  );

  always #2.5 clk = ~clk;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string tag = "R8";

  // reference model state
  logic [15:0] mbuf[4];
  logic [15:0] mlat[4];
  logic [1:0]  mpd[4];
  logic [1:0]  mclr;
  logic [3:0]  mdir, milim, mselop, mselch;
  logic        msdo, mrdy;

  function automatic logic [31:0] frame(input bit rd, input int op, input int ch,
                                        input logic [15:0] d, input logic [3:0] m);
    return {3'b000, rd, 4'(op), 4'(ch), d, m};
  endfunction

  task automatic model_por(input bit mid);
    for (int i = 0; i < 4; i++) begin
      mbuf[i] = mid ? 16'h8000 : 16'h0000;
      mlat[i] = mbuf[i];
      mpd[i]  = 2'b00;
    end
    mclr = 0; mdir = 0; milim = 0; msdo = 0; mselop = 4'hE; mselch = 0;
  endtask

  function automatic logic [15:0] clr_val(input logic [1:0] s);
    if (s == 2'b01) return 16'h8000;
    if (s == 2'b10) return 16'hFFFF;
    return 16'h0000;
  endfunction

  task automatic model_apply(input logic [31:0] w);
    int op, ch;
    logic [15:0] d;
    logic [3:0]  m;
    bit okch;
    op = int'(w[27:24]); ch = int'(w[23:20]); d = w[19:4]; m = w[3:0];
    okch = (ch < 4) || (ch == 15);
    if (w[28]) begin
      mselop = w[27:24]; mselch = w[23:20];
    end else begin
      case (op)
        0: for (int i = 0; i < 4; i++)
             if (ch == i || ch == 15) begin mbuf[i] = d; if (mdir[i]) mlat[i] = d; end
        1: for (int i = 0; i < 4; i++) if (ch == i || ch == 15) mlat[i] = mbuf[i];
        2: if (okch) begin
             for (int i = 0; i < 4; i++) if (ch == i || ch == 15) mbuf[i] = d;
             for (int i = 0; i < 4; i++) mlat[i] = mbuf[i];
           end
        3: for (int i = 0; i < 4; i++)
             if (ch == i || ch == 15) begin mbuf[i] = d; mlat[i] = d; end
        4: for (int i = 0; i < 4; i++) if (m[i]) mpd[i] = d[5:4];
        5: mclr = m[1:0];
        6: mdir = m;
        7: model_por(por_mid);
        8: msdo = m[1];
        10: milim = m;
        11: for (int i = 0; i < 4; i++) begin mbuf[i] = clr_val(mclr); mlat[i] = mbuf[i]; end
        default: ;
      endcase
    end
  endtask

  function automatic logic [31:0] exp_rd();
    logic [15:0] d;
    logic [3:0]  m;
    d = 0; m = 0;
    case (mselop)
      4'h0: if (mselch < 4) d = mbuf[mselch];
      4'h4: d[7:0] = {mpd[3], mpd[2], mpd[1], mpd[0]};
      4'h5: m[1:0] = mclr;
      4'h6: m = mdir;
      4'h8: m[1] = msdo;
      4'hA: m = milim;
      4'hD: d[0] = mrdy;
      default: ;
    endcase
    return {4'h0, mselop, mselch, d, m};
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk("dac_code", dac_code, {mlat[3], mlat[2], mlat[1], mlat[0]});
    chk("pd_mode", 64'(pd_mode), 64'({mpd[3], mpd[2], mpd[1], mpd[0]}));
    chk("clr_mode", 64'(clr_mode), 64'(mclr));
    chk("ldac_ign", 64'(ldac_ign), 64'(mdir));
    chk("sc_lim", 64'(sc_lim), 64'(milim));
    chk("sdo_en", 64'(sdo_en), 64'(msdo));
    chk("ready", 64'(ready), 64'(mrdy));
    chk("rd_word", 64'(rd_word), 64'(exp_rd()));
  endtask

  task automatic step(input bit v, input logic [31:0] w);
    cmd_valid = v;
    cmd_word  = w;
    @(posedge clk);
    if (rst_n) begin
      if (v) model_apply(w);
      mrdy = 1'b1;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    check_all();
  endtask

  task automatic send(input logic [31:0] w);
    step(1'b1, w);
  endtask

  task automatic do_reset(input bit mid);
    @(negedge clk);
    por_mid = mid;
    rst_n = 1'b0;
    model_por(mid);
    mrdy = 1'b0;
    #1;
    check_all();
    step(1'b0, 32'h0);
    step(1'b1, frame(0, 3, 0, 16'h1234, 0));
    rst_n = 1'b1;
    step(1'b0, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tag = "R8"; do_reset(1'b0);
    tag = "R9"; step(0, 0);
    tag = "R1"; step(0, frame(0, 3, 0, 16'hDEAD, 0));
    send({3'b111, 1'b0, 4'h3, 4'h0, 16'hA5A5, 4'h0});
    tag = "R3"; send(frame(0, 0, 1, 16'h1234, 0));
    tag = "R4"; send(frame(0, 1, 1, 0, 0));
    send(frame(0, 3, 2, 16'hBEEF, 0));
    tag = "R2"; send(frame(0, 3, 5, 16'h4444, 0));
    send(frame(0, 0, 15, 16'h5555, 0));
    send(frame(0, 2, 9, 16'h6666, 0));
    tag = "R4"; send(frame(0, 2, 2, 16'h7777, 0));
    tag = "R3"; send(frame(0, 6, 0, 0, 4'b0101));
    send(frame(0, 0, 0, 16'h1111, 0));
    send(frame(0, 0, 1, 16'h2222, 0));
    send(frame(0, 0, 15, 16'h3030, 0));
    tag = "R5"; send(frame(0, 4, 0, 16'h0020, 4'b1010));
    send(frame(0, 3, 1, 16'h3333, 0));
    send(frame(0, 4, 0, 16'h0030, 4'b0001));
    send(frame(0, 4, 0, 16'h0000, 4'b0010));
    tag = "R6"; send(frame(0, 5, 0, 0, 4'b0001));
    send(frame(0, 10, 0, 0, 4'b0110));
    send(frame(0, 8, 0, 0, 4'b0010));
    send(frame(0, 6, 0, 0, 4'b0000));
    tag = "R7"; send(frame(0, 11, 0, 0, 0));
    send(frame(0, 5, 0, 0, 4'b0010));
    send(frame(0, 11, 0, 0, 0));
    chk("full-scale clear", dac_code, {4{16'hFFFF}});
    send(frame(0, 5, 0, 0, 4'b0011));
    send(frame(0, 11, 0, 0, 0));
    chk("selection 11 clears to zero", dac_code, 64'h0);
    tag = "R10"; send(frame(0, 0, 1, 16'hC0DE, 0));
    send(frame(1, 0, 1, 0, 0));
    chk("buffer readback", 64'(rd_word[19:4]), 64'h00C0DE);
    send(frame(1, 0, 7, 0, 0));
    send(frame(0, 4, 0, 16'h0010, 4'b1000));
    send(frame(1, 4, 0, 0, 0));
    send(frame(1, 5, 0, 0, 0));
    send(frame(1, 6, 0, 0, 0));
    send(frame(1, 8, 0, 0, 0));
    send(frame(1, 10, 0, 0, 0));
    send(frame(1, 13, 0, 0, 0));
    chk("status ready bit", 64'(rd_word[4]), 64'h1);
    send(frame(1, 3, 0, 16'h9999, 4'hF));
    send(frame(1, 11, 0, 0, 0));
    tag = "R11";
    send(frame(0, 9, 15, 16'hFFFF, 4'hF));
    send(frame(0, 12, 0, 16'h1357, 4'hF));
    send(frame(0, 15, 3, 16'h2468, 4'hF));
    send(frame(0, 14, 15, 16'hFFFF, 4'hF));
    tag = "R8"; send(frame(0, 7, 0, 0, 0));
    do_reset(1'b1);
    send(frame(0, 3, 15, 16'h0F0F, 0));
    send(frame(0, 6, 0, 0, 4'hF));
    tag = "R9"; send(frame(0, 7, 0, 0, 0));
    chk("ready after software reset", 64'(ready), 64'h1);
    tag = "R1";
    for (int k = 0; k < 40; k++) begin
      logic [31:0] w;
      w = 32'(k) * 32'h9E3779B9 + 32'h1234567;
      step(k[0], w);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule